// File: doc/BRIEF.md
# Ethernet Transmit Status Register

This block keeps the 16-bit transmit status word of an Ethernet MAC transmitter. The MAC engine reports per-frame events to it as single-cycle pulses: frame start with its destination type, underrun, late collision, deferral, excessive deferral, sixteen collisions, single and multiple collisions, success and packet completion. The block applies a separate set and clear rule to each bit. Some bits clear when the host re-enables transmission, some at the end of every packet, some at the start of every frame, and one when the event counter register is read.

Underrun, late collision, sixteen collisions and a signal quality error with stop-on-error enabled each raise a one-cycle request to drop the transmit-enable control bit. A synchronized, inverted copy of the active-low link pin sits in the word, and each change of it raises a one-cycle link interrupt. When a packet completes, the block presents the full word with a one-cycle write strobe, so packet memory can store it as the first word of that packet's buffer.

Top module: `tx_status_reg`

## Requirements
- R1: During and after reset, status_word reads 0x0000 while link_n is high, and link_irq, txen_clr_req, eph_irq and snap_we are low.
- R2: Bits 13, 10 and 8 of status_word and snap_word always read zero.
- R3: Bit 14 equals the inverted link_n after SYNC_STAGES register stages, and link_irq is high for exactly the one cycle in which bit 14 differs from its value in the previous cycle.
- R4: Bit 15 (underrun) sets on ev_underrun only while early_tx_en is high, and then raises txen_clr_req. With early_tx_en low the event changes no output. The bit clears on txen_set.
- R5: Bit 9 (late collision) sets on ev_late_col and bit 4 (sixteen collisions) sets on ev_col16. Each raises txen_clr_req, and both bits clear on txen_set.
- R6: Bit 7 (deferred) sets on ev_defer and bit 11 (excessive deferral) sets on ev_exc_defer. Both clear on ev_pkt_done.
- R7: On frame_start, bit 6 loads frame_bcast and bit 3 loads frame_mcast. Bits 2 (multiple collision), 1 (single collision) and 0 (success) clear on frame_start and set on ev_multi_col, ev_single_col and ev_tx_ok.
- R8: Bit 12 (counter rollover) sets on ctr_max and clears on ctr_read.
- R9: Bit 5 (SQE test) sets on ev_pkt_done while fdx_sw is low. If stop_on_sqe is also high, eph_irq and txen_clr_req pulse. The bit clears on txen_set.
- R10: A set event in the same cycle as a clear event for the same bit leaves the bit set.
- R11: The cycle after ev_pkt_done, snap_we is high for one cycle. snap_word then holds every update of that cycle except the end-of-packet clears, and bit 14 holds the link bit as it was in the completion cycle.
- R12: status_word, txen_clr_req and eph_irq change in the clock cycle after the event that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_n | input | 1 | Asynchronous active-low link pin |
| early_tx_en | input | 1 | Early transmit mode in use |
| fdx_sw | input | 1 | Full-duplex switching on |
| stop_on_sqe | input | 1 | Stop transmission on SQE test |
| txen_set | input | 1 | Host sets transmit enable (pulse) |
| ctr_read | input | 1 | Event counter register read (pulse) |
| frame_start | input | 1 | Start of a transmit frame (pulse) |
| frame_bcast | input | 1 | Frame is broadcast, valid with frame_start |
| frame_mcast | input | 1 | Frame is multicast, valid with frame_start |
| ev_underrun | input | 1 | Transmit underrun |
| ev_late_col | input | 1 | Late collision |
| ev_defer | input | 1 | Carrier seen early in the inter-frame gap |
| ev_exc_defer | input | 1 | Deferral exceeded 3036 byte times |
| ev_col16 | input | 1 | Sixteenth collision on the frame |
| ev_single_col | input | 1 | Frame had one collision |
| ev_multi_col | input | 1 | Frame had several collisions |
| ev_tx_ok | input | 1 | Frame sent successfully |
| ev_pkt_done | input | 1 | Packet completion |
| ctr_max | input | 1 | A 4-bit event counter reached 15 |
| status_word | output | 16 | Live status word |
| link_irq | output | 1 | Link status change pulse |
| txen_clr_req | output | 1 | Request to clear transmit enable |
| eph_irq | output | 1 | Stop-on-SQE interrupt pulse |
| snap_we | output | 1 | Snapshot write strobe |
| snap_word | output | 16 | Status word captured at packet completion |

## Verification
Random stimulus fires every event pulse, the three configuration inputs and the link pin at low, independent rates. Clears and sets therefore meet in the same cycle often, and this separates a set-priority merge from a clear-priority one. Directed cases test each bit alone. Underrun is driven with and without early transmit, which shows whether the gating is present. Packet completion is driven with and without a pending deferral, which shows whether the snapshot is taken before or after the end-of-packet clear. Completion is also driven under full-duplex switching and under stop-on-SQE, which separates the three SQE outcomes.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    localparam int STAT_W = 16;

    // Bit positions inside the status word
    localparam int B_UNDERRUN = 15;
    localparam int B_LINK     = 14;
    localparam int B_CROLL    = 12;
    localparam int B_EXCDEF   = 11;
    localparam int B_LATECOL  = 9;
    localparam int B_DEFER    = 7;
    localparam int B_BCAST    = 6;
    localparam int B_SQE      = 5;
    localparam int B_COL16    = 4;
    localparam int B_MCAST    = 3;
    localparam int B_MULTI    = 2;
    localparam int B_SINGLE   = 1;
    localparam int B_TXOK     = 0;

    typedef struct packed {
        logic underrun;
        logic ctr_roll;
        logic exc_defer;
        logic late_col;
        logic defer;
        logic bcast;
        logic sqe;
        logic col16;
        logic mcast;
        logic multi_col;
        logic single_col;
        logic tx_ok;
    } flags_t;

    typedef struct packed {
        logic frame_start;
        logic is_bcast;
        logic is_mcast;
        logic underrun;
        logic late_col;
        logic defer;
        logic exc_defer;
        logic col16;
        logic single_col;
        logic multi_col;
        logic tx_ok;
        logic pkt_done;
        logic ctr_max;
    } tx_evt_t;

    function automatic logic [STAT_W-1:0] pack_word(flags_t f, logic link);
        logic [STAT_W-1:0] w;
        w             = '0;
        w[B_UNDERRUN] = f.underrun;
        w[B_LINK]     = link;
        w[B_CROLL]    = f.ctr_roll;
        w[B_EXCDEF]   = f.exc_defer;
        w[B_LATECOL]  = f.late_col;
        w[B_DEFER]    = f.defer;
        w[B_BCAST]    = f.bcast;
        w[B_SQE]      = f.sqe;
        w[B_COL16]    = f.col16;
        w[B_MCAST]    = f.mcast;
        w[B_MULTI]    = f.multi_col;
        w[B_SINGLE]   = f.single_col;
        w[B_TXOK]     = f.tx_ok;
        return w;
    endfunction

endpackage

// File: rtl/tsr_link_sync.sv
module tsr_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_n_i,
    output logic link_ok_o,
    output logic link_chg_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign chain_d[i] = ~link_n_i;
            end else begin : g_next
                assign chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    always_comb begin
        prev_d = chain_q[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign link_ok_o  = chain_q[LAST];
    assign link_chg_o = chain_q[LAST] ^ prev_q;

endmodule

// File: rtl/tsr_flag_core.sv
module tsr_flag_core
    import tsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  tx_evt_t evt_i,
    input  logic    early_tx_en_i,
    input  logic    fdx_sw_i,
    input  logic    stop_on_sqe_i,
    input  logic    txen_set_i,
    input  logic    ctr_read_i,
    output flags_t  flags_o,
    output flags_t  snap_flags_o,
    output logic    snap_we_o,
    output logic    txen_clr_o,
    output logic    eph_irq_o
);
    typedef struct packed {
        flags_t flags;
        flags_t snap;
        logic   snap_we;
        logic   txen_clr;
        logic   eph_irq;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        flags_t f;
        logic   ur_set;
        logic   sqe_set;
        logic   sqe_stop;

        st_d = st_q;
        f    = st_q.flags;

        ur_set   = evt_i.underrun & early_tx_en_i;
        sqe_set  = evt_i.pkt_done & ~fdx_sw_i;
        sqe_stop = sqe_set & stop_on_sqe_i;

        // Clears: re-enable of transmit
        if (txen_set_i) begin
            f.underrun = 1'b0;
            f.late_col = 1'b0;
            f.sqe      = 1'b0;
            f.col16    = 1'b0;
        end
        // Clear: counter register read
        if (ctr_read_i) begin
            f.ctr_roll = 1'b0;
        end
        // Frame start: type flags load, outcome flags clear
        if (evt_i.frame_start) begin
            f.bcast      = evt_i.is_bcast;
            f.mcast      = evt_i.is_mcast;
            f.multi_col  = 1'b0;
            f.single_col = 1'b0;
            f.tx_ok      = 1'b0;
        end

        // Sets, applied last so they win over any clear
        if (ur_set)              f.underrun   = 1'b1;
        if (evt_i.late_col)      f.late_col   = 1'b1;
        if (evt_i.exc_defer)     f.exc_defer  = 1'b1;
        if (evt_i.defer)         f.defer      = 1'b1;
        if (evt_i.col16)         f.col16      = 1'b1;
        if (evt_i.single_col)    f.single_col = 1'b1;
        if (evt_i.multi_col)     f.multi_col  = 1'b1;
        if (evt_i.tx_ok)         f.tx_ok      = 1'b1;
        if (evt_i.ctr_max)       f.ctr_roll   = 1'b1;
        if (sqe_set)             f.sqe        = 1'b1;

        // Snapshot before the end-of-packet clears
        if (evt_i.pkt_done) begin
            st_d.snap = f;
        end
        st_d.snap_we = evt_i.pkt_done;

        // End-of-packet clears, unless set this same cycle
        if (evt_i.pkt_done) begin
            if (!evt_i.defer)     f.defer     = 1'b0;
            if (!evt_i.exc_defer) f.exc_defer = 1'b0;
        end

        st_d.flags    = f;
        st_d.txen_clr = ur_set | evt_i.late_col | evt_i.col16 | sqe_stop;
        st_d.eph_irq  = sqe_stop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o      = st_q.flags;
    assign snap_flags_o = st_q.snap;
    assign snap_we_o    = st_q.snap_we;
    assign txen_clr_o   = st_q.txen_clr;
    assign eph_irq_o    = st_q.eph_irq;

endmodule

// File: rtl/tx_status_reg.sv
module tx_status_reg
    import tsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_n,
    input  logic              early_tx_en,
    input  logic              fdx_sw,
    input  logic              stop_on_sqe,
    input  logic              txen_set,
    input  logic              ctr_read,
    input  logic              frame_start,
    input  logic              frame_bcast,
    input  logic              frame_mcast,
    input  logic              ev_underrun,
    input  logic              ev_late_col,
    input  logic              ev_defer,
    input  logic              ev_exc_defer,
    input  logic              ev_col16,
    input  logic              ev_single_col,
    input  logic              ev_multi_col,
    input  logic              ev_tx_ok,
    input  logic              ev_pkt_done,
    input  logic              ctr_max,
    output logic [STAT_W-1:0] status_word,
    output logic              link_irq,
    output logic              txen_clr_req,
    output logic              eph_irq,
    output logic              snap_we,
    output logic [STAT_W-1:0] snap_word
);
    tx_evt_t evt;
    flags_t  flags;
    flags_t  snap_flags;
    logic    link_ok;
    logic    snap_link_d, snap_link_q;

    always_comb begin
        evt             = '0;
        evt.frame_start = frame_start;
        evt.is_bcast    = frame_bcast;
        evt.is_mcast    = frame_mcast;
        evt.underrun    = ev_underrun;
        evt.late_col    = ev_late_col;
        evt.defer       = ev_defer;
        evt.exc_defer   = ev_exc_defer;
        evt.col16       = ev_col16;
        evt.single_col  = ev_single_col;
        evt.multi_col   = ev_multi_col;
        evt.tx_ok       = ev_tx_ok;
        evt.pkt_done    = ev_pkt_done;
        evt.ctr_max     = ctr_max;
    end

    tsr_link_sync #(
        .STAGES (SYNC_STAGES)
    ) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_n_i   (link_n),
        .link_ok_o  (link_ok),
        .link_chg_o (link_irq)
    );

    tsr_flag_core u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_i         (evt),
        .early_tx_en_i (early_tx_en),
        .fdx_sw_i      (fdx_sw),
        .stop_on_sqe_i (stop_on_sqe),
        .txen_set_i    (txen_set),
        .ctr_read_i    (ctr_read),
        .flags_o       (flags),
        .snap_flags_o  (snap_flags),
        .snap_we_o     (snap_we),
        .txen_clr_o    (txen_clr_req),
        .eph_irq_o     (eph_irq)
    );

    always_comb begin
        snap_link_d = ev_pkt_done ? link_ok : snap_link_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_link_q <= 1'b0;
        end else begin
            snap_link_q <= snap_link_d;
        end
    end

    assign status_word = pack_word(flags, link_ok);
    assign snap_word   = pack_word(snap_flags, snap_link_q);

endmodule

// File: rtl/tsr_checker.sv
module tsr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        early_tx_en,
    input logic        txen_set,
    input logic        ev_underrun,
    input logic        ev_col16,
    input logic        ev_pkt_done,
    input logic        ctr_max,
    input logic [15:0] status_word,
    input logic        link_irq,
    input logic        txen_clr_req,
    input logic        eph_irq,
    input logic        snap_we,
    input logic [15:0] snap_word
);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[13] == 1'b0) && (status_word[10] == 1'b0) && (status_word[8] == 1'b0)
        && (snap_word[13] == 1'b0) && (snap_word[10] == 1'b0) && (snap_word[8] == 1'b0));

    assert_link_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        link_irq == (status_word[14] != $past(status_word[14])));

    assert_underrun_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_underrun && !early_tx_en && !status_word[15]) |=> !status_word[15]);

    assert_col16_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_col16 |=> (txen_clr_req && status_word[4]));

    assert_rollover_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_max |=> status_word[12]);

    assert_eph_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eph_irq |-> txen_clr_req);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (txen_set && ev_col16) |=> status_word[4]);

    assert_snap_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pkt_done |=> snap_we);

    assert_snap_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_pkt_done |=> !snap_we);

endmodule

bind tx_status_reg tsr_checker u_tsr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .early_tx_en  (early_tx_en),
    .txen_set     (txen_set),
    .ev_underrun  (ev_underrun),
    .ev_col16     (ev_col16),
    .ev_pkt_done  (ev_pkt_done),
    .ctr_max      (ctr_max),
    .status_word  (status_word),
    .link_irq     (link_irq),
    .txen_clr_req (txen_clr_req),
    .eph_irq      (eph_irq),
    .snap_we      (snap_we),
    .snap_word    (snap_word)
);

// File: tb/test_tx_status_reg.sv
`timescale 1ns/1ps
module test_tx_status_reg;

    logic clk = 1'b0;
    logic rst_n;
    logic link_n, early_tx_en, fdx_sw, stop_on_sqe, txen_set, ctr_read;
    logic frame_start, frame_bcast, frame_mcast;
    logic ev_underrun, ev_late_col, ev_defer, ev_exc_defer, ev_col16;
    logic ev_single_col, ev_multi_col, ev_tx_ok, ev_pkt_done, ctr_max;
    logic [15:0] status_word, snap_word;
    logic link_irq, txen_clr_req, eph_irq, snap_we;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    logic [15:0] m_word;
    logic [15:0] m_snap;
    logic        m_snap_we, m_clr, m_eph;
    logic        m_s1, m_s2, m_prev;

    always #5 clk = ~clk;

    tx_status_reg i_tx_status_reg (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_pulses();
        txen_set = 0; ctr_read = 0; frame_start = 0; frame_bcast = 0; frame_mcast = 0;
        ev_underrun = 0; ev_late_col = 0; ev_defer = 0; ev_exc_defer = 0; ev_col16 = 0;
        ev_single_col = 0; ev_multi_col = 0; ev_tx_ok = 0; ev_pkt_done = 0; ctr_max = 0;
    endtask

    task automatic model_reset();
        m_word = '0; m_snap = '0; m_snap_we = 0; m_clr = 0; m_eph = 0;
        m_s1 = 0; m_s2 = 0; m_prev = 0;
    endtask

    // Next state of the model from the current inputs (R4-related rules written per bit)
    task automatic model_step();
        logic [15:0] w;
        logic ur, sqe, stop;
        w = m_word;
        ur   = ev_underrun & early_tx_en;
        sqe  = ev_pkt_done & ~fdx_sw;
        stop = sqe & stop_on_sqe;
        if (txen_set) begin w[15] = 0; w[9] = 0; w[5] = 0; w[4] = 0; end
        if (ctr_read) w[12] = 0;
        if (frame_start) begin
            w[6] = frame_bcast; w[3] = frame_mcast; w[2] = 0; w[1] = 0; w[0] = 0;
        end
        if (ur)            w[15] = 1;
        if (ev_late_col)   w[9]  = 1;
        if (ev_exc_defer)  w[11] = 1;
        if (ev_defer)      w[7]  = 1;
        if (ev_col16)      w[4]  = 1;
        if (ev_single_col) w[1]  = 1;
        if (ev_multi_col)  w[2]  = 1;
        if (ev_tx_ok)      w[0]  = 1;
        if (ctr_max)       w[12] = 1;
        if (sqe)           w[5]  = 1;
        if (ev_pkt_done) begin
            m_snap = w;
            m_snap[14] = m_s2;
            if (!ev_defer)     w[7]  = 0;
            if (!ev_exc_defer) w[11] = 0;
        end
        m_snap_we = ev_pkt_done;
        m_word = w;
        m_clr  = ur | ev_late_col | ev_col16 | stop;
        m_eph  = stop;
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = ~link_n;
    endtask

    // One clock: model advances, outputs compared after the edge (R12)
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check("R12 status", status_word, {m_word[15], m_s2, m_word[13:0]});
        check("R3 link_irq", link_irq, m_s2 ^ m_prev);
        check("R12 txen_clr_req", txen_clr_req, m_clr);
        check("R9 eph_irq", eph_irq, m_eph);
        check("R11 snap_we", snap_we, m_snap_we);
        if (m_snap_we) check("R11 snap_word", snap_word, m_snap);
    endtask

    initial begin
        #(150000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 0; link_n = 1; early_tx_en = 0; fdx_sw = 0; stop_on_sqe = 0;
        clear_pulses();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset status", status_word, 16'h0000);
        check("R1 reset outputs", {link_irq, txen_clr_req, eph_irq, snap_we}, 4'b0000);
        rst_n = 1;
        cyc();
        check("R1 after reset", status_word, 16'h0000);

        // R3: link comes up, seen after two stages, one irq pulse
        link_n = 0; cyc(); link_n = 0;
        check("R3 link not yet", status_word[14], 1'b0);
        cyc();
        check("R3 link up", status_word[14], 1'b1);
        check("R3 irq pulse", link_irq, 1'b1);
        cyc();
        check("R3 irq single", link_irq, 1'b0);

        // R4: underrun ignored without early transmit
        ev_underrun = 1; early_tx_en = 0; cyc(); clear_pulses();
        check("R4 ignored bit", status_word[15], 1'b0);
        check("R4 ignored req", txen_clr_req, 1'b0);
        early_tx_en = 1; ev_underrun = 1; cyc(); clear_pulses();
        check("R4 set", status_word[15], 1'b1);
        check("R4 req", txen_clr_req, 1'b1);
        txen_set = 1; cyc(); clear_pulses();
        check("R4 clear", status_word[15], 1'b0);

        // R5: late collision and sixteen collisions
        ev_late_col = 1; cyc(); clear_pulses();
        check("R5 late col", {status_word[9], txen_clr_req}, 2'b11);
        ev_col16 = 1; cyc(); clear_pulses();
        check("R5 col16", {status_word[4], txen_clr_req}, 2'b11);
        txen_set = 1; cyc(); clear_pulses();
        check("R5 cleared", {status_word[9], status_word[4]}, 2'b00);

        // R10: set and clear in the same cycle
        txen_set = 1; ev_col16 = 1; cyc(); clear_pulses();
        check("R10 set wins", status_word[4], 1'b1);
        txen_set = 1; cyc(); clear_pulses();

        // R6 and R11: deferral captured in the snapshot, cleared live
        fdx_sw = 1;
        ev_defer = 1; ev_exc_defer = 1; cyc(); clear_pulses();
        check("R6 set", {status_word[11], status_word[7]}, 2'b11);
        ev_pkt_done = 1; cyc(); clear_pulses();
        check("R6 cleared at end", {status_word[11], status_word[7]}, 2'b00);
        check("R11 snap has defer", {snap_we, snap_word[11], snap_word[7], snap_word[14]}, 4'b1111);
        cyc();
        check("R11 strobe one cycle", snap_we, 1'b0);

        // R7: frame type and outcome flags
        ev_tx_ok = 1; ev_single_col = 1; cyc(); clear_pulses();
        frame_start = 1; frame_bcast = 1; cyc(); clear_pulses();
        check("R7 bcast frame", {status_word[6], status_word[3], status_word[1], status_word[0]}, 4'b1000);
        frame_start = 1; frame_mcast = 1; ev_multi_col = 1; cyc(); clear_pulses();
        check("R7 mcast frame", {status_word[6], status_word[3], status_word[2]}, 3'b011);

        // R8: counter rollover
        ctr_max = 1; cyc(); clear_pulses();
        check("R8 set", status_word[12], 1'b1);
        ctr_read = 1; cyc(); clear_pulses();
        check("R8 clear", status_word[12], 1'b0);

        // R9: SQE outcomes
        ev_pkt_done = 1; cyc(); clear_pulses();
        check("R9 fdx suppresses", status_word[5], 1'b0);
        fdx_sw = 0; stop_on_sqe = 0; ev_pkt_done = 1; cyc(); clear_pulses();
        check("R9 set no stop", {status_word[5], eph_irq, txen_clr_req}, 3'b100);
        stop_on_sqe = 1; ev_pkt_done = 1; cyc(); clear_pulses();
        check("R9 stop", {status_word[5], eph_irq, txen_clr_req}, 3'b111);
        stop_on_sqe = 0;

        // R2: everything set, reserved bits remain zero
        ev_underrun = 1; ev_late_col = 1; ev_defer = 1; ev_exc_defer = 1; ev_col16 = 1;
        ctr_max = 1; frame_start = 1; frame_bcast = 1; frame_mcast = 1; ev_tx_ok = 1;
        ev_single_col = 1; ev_multi_col = 1; ev_pkt_done = 1;
        cyc(); clear_pulses();
        check("R2 reserved live", status_word & 16'h2500, 16'h0000);
        check("R2 reserved snap", snap_word & 16'h2500, 16'h0000);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(15) == 0) early_tx_en = $urandom_range(1);
            if ($urandom_range(15) == 0) fdx_sw      = $urandom_range(1);
            if ($urandom_range(15) == 0) stop_on_sqe = $urandom_range(1);
            if ($urandom_range(31) == 0) link_n      = ~link_n;
            txen_set      = ($urandom_range(9) == 0);
            ctr_read      = ($urandom_range(9) == 0);
            frame_start   = ($urandom_range(5) == 0);
            frame_bcast   = $urandom_range(1);
            frame_mcast   = $urandom_range(1);
            ev_underrun   = ($urandom_range(11) == 0);
            ev_late_col   = ($urandom_range(11) == 0);
            ev_defer      = ($urandom_range(7) == 0);
            ev_exc_defer  = ($urandom_range(9) == 0);
            ev_col16      = ($urandom_range(11) == 0);
            ev_single_col = ($urandom_range(7) == 0);
            ev_multi_col  = ($urandom_range(7) == 0);
            ev_tx_ok      = ($urandom_range(5) == 0);
            ev_pkt_done   = ($urandom_range(5) == 0);
            ctr_max       = ($urandom_range(9) == 0);
            cyc();
        end
        clear_pulses();
        cyc();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule